// File: doc/BRIEF.md
# Bipolar Burst Receiver with Superframe Alignment

This block takes one burst of a half-bauded three-level line code at a time. Each bit arrives as a pair of sliced samples, one for each polarity, with a qualifier. A start strobe marks the first sample of every burst. The block decodes marks and spaces and splits each burst into two byte channels, a 4-bit side channel and a single maintenance bit. It tracks pulse polarity so that it can spot bipolar violations.

A violation that falls on the maintenance bit is not an error. It is the superframe marker, and the block follows it across a four-burst cycle. Once aligned, it takes two transparent bits and one service bit out of the maintenance slot in every cycle of four bursts. Violations inside the data fields and samples that show both polarities at once are reported as one-cycle error flags.

Clock recovery, slicing and line-delay measurement are not part of this block. The sample clock and the start strobe come from outside.

Top module: `amiSuperframeRx`

## Requirements
- R1: During and straight after reset, every output is 0, including `sfLock`, all strobes and all field registers.
- R2: A qualified sample decodes as 1 when exactly one of `linePos`/`lineNeg` is high, and as 0 when both are low. The burst is decoded in this order:
  - one framing sample, flagged by `burstStart` and not delivered as data;
  - 8 bits into `b1Out`;
  - 8 bits into `b2Out`;
  - 4 bits into `dOut`;
  - 1 maintenance bit.
  
  Each field is filled MSB first, so the first bit received lands in the top bit.
- R3: `fieldValid` pulses high for exactly one cycle, one cycle after the maintenance sample is accepted. At that moment `b1Out`, `b2Out` and `dOut` hold the complete fields of that burst.
- R4: A mark with the same polarity as the previous mark in the same burst is a violation. The framing sample sets the first reference. A violation in the B1, B2 or D fields raises `cvErr` for one cycle, one cycle after that sample, and still decodes as 1. A violation does not clear the polarity reference, so the mark right after it is checked against it.
- R5: A qualified sample with both `linePos` and `lineNeg` high raises `symErr` one cycle later. It decodes as 0 and leaves the polarity reference unchanged.
- R6: Samples with `sampleValid` low are ignored. Samples after the maintenance bit, such as the balancing bit that follows a marker, are ignored until the next `burstStart`. They raise no flag.
- R7: `sfLock` rises after two maintenance-slot violations (markers) that are exactly four bursts apart. It becomes visible in the same cycle as the `fieldValid` of the second marker's burst.
- R8: While locked, counting the marker burst as position 0:
  - bursts at positions 1 and 3 give a `tValid` pulse with `tBit` equal to the maintenance bit;
  - position 2 gives an `sValid` pulse with `sBit` equal to the maintenance bit.
  
  Both pulses coincide with `fieldValid`. No such strobe is given while unlocked.
- R9: Lock is lost after two consecutive faults. A fault is either a missing marker at position 0 or a marker at any other position. A marker at a wrong position re-aligns the count, so a marker four bursts later locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Qualifies the current line sample |
| burstStart | input | 1 | Marks the framing sample of a burst |
| linePos | input | 1 | Positive pulse detected |
| lineNeg | input | 1 | Negative pulse detected |
| fieldValid | output | 1 | One-cycle strobe: burst fields complete |
| b1Out | output | 8 | First byte channel |
| b2Out | output | 8 | Second byte channel |
| dOut | output | 4 | Side channel |
| tValid | output | 1 | Transparent bit strobe |
| tBit | output | 1 | Transparent bit value |
| sValid | output | 1 | Service bit strobe |
| sBit | output | 1 | Service bit value |
| sfLock | output | 1 | Superframe alignment held |
| cvErr | output | 1 | Violation inside a data field |
| symErr | output | 1 | Both polarities asserted |

## Verification
All results are registered once. `cvErr` and `symErr` appear one cycle after the offending sample, and `fieldValid`, the channel strobes and any change of `sfLock` appear one cycle after the maintenance sample. The bench drives each sample on a falling edge, so the accepting rising edge follows half a period later. It reads burst results at the very next falling edge after the maintenance sample, and checks at the falling edge after that that `fieldValid` has dropped. Error pulses are counted on every falling edge and compared once the burst plus one idle cycle has passed. That way, a flag raised by an ignored trailing sample is also caught.

// File: rtl/amiRxPkg.sv
package amiRxPkg;
  // slot strobes from control to datapath, each already qualified by sampleValid
  typedef struct packed {
    logic frameStart;
    logic inB1;
    logic inB2;
    logic inD;
    logic inM;
  } slotStrb_t;

  localparam int SF_LEN = 4;
  localparam int PH_W = $clog2(SF_LEN);
endpackage

// File: rtl/amiRxDatapath.sv
module amiRxDatapath
  import amiRxPkg::*;
#(
  parameter int B_W = 8,
  parameter int D_W = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           linePos,
  input  logic           lineNeg,
  input  slotStrb_t      strb,
  output logic           markNow,
  output logic           cvNow,
  output logic           fieldValid,
  output logic [B_W-1:0] b1Out,
  output logic [B_W-1:0] b2Out,
  output logic [D_W-1:0] dOut,
  output logic           cvErr,
  output logic           symErr
);
  logic badNow, inData, violNow;
  logic polKnown, lastPos;

  assign markNow = linePos ^ lineNeg;
  assign badNow  = linePos & lineNeg;
  assign inData  = strb.inB1 | strb.inB2 | strb.inD | strb.inM;
  assign violNow = inData && markNow && polKnown && (linePos == lastPos);
  assign cvNow   = violNow && strb.inM;

  // polarity reference: re-seeded by the framing sample, updated by every mark
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polKnown <= 1'b0;
      lastPos  <= 1'b0;
    end else if (strb.frameStart) begin
      polKnown <= markNow;
      lastPos  <= linePos;
    end else if (inData && markNow) begin
      polKnown <= 1'b1;
      lastPos  <= linePos;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b1Out      <= '0;
      b2Out      <= '0;
      dOut       <= '0;
      fieldValid <= 1'b0;
      cvErr      <= 1'b0;
      symErr     <= 1'b0;
    end else begin
      if (strb.inB1) b1Out <= {b1Out[B_W-2:0], markNow};
      if (strb.inB2) b2Out <= {b2Out[B_W-2:0], markNow};
      if (strb.inD)  dOut  <= {dOut[D_W-2:0], markNow};
      fieldValid <= strb.inM;
      cvErr      <= violNow && !strb.inM;
      symErr     <= badNow && (strb.frameStart || inData);
    end
  end
endmodule

// File: rtl/amiRxControl.sv
module amiRxControl
  import amiRxPkg::*;
#(
  parameter int B_W        = 8,
  parameter int D_W        = 4,
  parameter int LOSS_LIMIT = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  input  logic      burstStart,
  input  logic      markNow,
  input  logic      cvNow,
  output slotStrb_t strb,
  output logic      sfLock,
  output logic      tValid,
  output logic      tBit,
  output logic      sValid,
  output logic      sBit
);
  localparam int M_IDX = 1 + 2 * B_W + D_W;
  localparam int IDX_W = $clog2(M_IDX + 1);
  localparam logic [IDX_W-1:0] B1_END = IDX_W'(B_W);
  localparam logic [IDX_W-1:0] B2_END = IDX_W'(2 * B_W);
  localparam logic [IDX_W-1:0] D_END  = IDX_W'(2 * B_W + D_W);
  localparam int FLT_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [FLT_W-1:0] FLT_MAX = FLT_W'(LOSS_LIMIT - 1);

  logic [IDX_W-1:0] idx;
  logic             active;
  logic [PH_W-1:0]  phase;
  logic             haveRef;
  logic [FLT_W-1:0] faults;
  logic             expectCv;

  always_comb begin
    strb = '0;
    if (sampleValid) begin
      if (burstStart)         strb.frameStart = 1'b1;
      else if (active) begin
        if (idx <= B1_END)      strb.inB1 = 1'b1;
        else if (idx <= B2_END) strb.inB2 = 1'b1;
        else if (idx <= D_END)  strb.inD  = 1'b1;
        else                    strb.inM  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      active <= 1'b0;
    end else if (strb.frameStart) begin
      idx    <= IDX_W'(1);
      active <= 1'b1;
    end else if (strb.inB1 || strb.inB2 || strb.inD) begin
      idx    <= idx + 1'b1;
    end else if (strb.inM) begin
      active <= 1'b0;
    end
  end

  assign expectCv = haveRef && (phase == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      haveRef <= 1'b0;
      faults  <= '0;
      sfLock  <= 1'b0;
      tValid  <= 1'b0;
      tBit    <= 1'b0;
      sValid  <= 1'b0;
      sBit    <= 1'b0;
    end else begin
      tValid <= 1'b0;
      sValid <= 1'b0;
      if (strb.inM) begin
        if (cvNow) begin
          phase   <= PH_W'(1);
          haveRef <= 1'b1;
          if (expectCv) begin
            sfLock <= 1'b1;
            faults <= '0;
          end else if (sfLock) begin
            if (faults == FLT_MAX) begin
              sfLock <= 1'b0;
              faults <= '0;
            end else faults <= faults + 1'b1;
          end
        end else begin
          phase <= phase + 1'b1;
          if (expectCv) begin
            if (sfLock) begin
              if (faults == FLT_MAX) begin
                sfLock  <= 1'b0;
                faults  <= '0;
                haveRef <= 1'b0;
              end else faults <= faults + 1'b1;
            end else haveRef <= 1'b0;
          end else if (sfLock) begin
            if (phase == PH_W'(2)) begin
              sValid <= 1'b1;
              sBit   <= markNow;
            end else begin
              tValid <= 1'b1;
              tBit   <= markNow;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/amiSuperframeRx.sv
module amiSuperframeRx
  import amiRxPkg::*;
#(
  parameter int B_W        = 8,
  parameter int D_W        = 4,
  parameter int LOSS_LIMIT = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleValid,
  input  logic           burstStart,
  input  logic           linePos,
  input  logic           lineNeg,
  output logic           fieldValid,
  output logic [B_W-1:0] b1Out,
  output logic [B_W-1:0] b2Out,
  output logic [D_W-1:0] dOut,
  output logic           tValid,
  output logic           tBit,
  output logic           sValid,
  output logic           sBit,
  output logic           sfLock,
  output logic           cvErr,
  output logic           symErr
);
  slotStrb_t strb;
  logic markNow, cvNow;

  amiRxControl #(.B_W(B_W), .D_W(D_W), .LOSS_LIMIT(LOSS_LIMIT)) ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .burstStart(burstStart),
    .markNow(markNow), .cvNow(cvNow), .strb(strb), .sfLock(sfLock),
    .tValid(tValid), .tBit(tBit), .sValid(sValid), .sBit(sBit)
  );

  amiRxDatapath #(.B_W(B_W), .D_W(D_W)) dp (
    .clk(clk), .rstN(rstN), .linePos(linePos), .lineNeg(lineNeg), .strb(strb),
    .markNow(markNow), .cvNow(cvNow), .fieldValid(fieldValid),
    .b1Out(b1Out), .b2Out(b2Out), .dOut(dOut), .cvErr(cvErr), .symErr(symErr)
  );
endmodule

// File: rtl/amiSuperframeRxChecker.sv
module amiSuperframeRxChecker (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic linePos,
  input logic lineNeg,
  input logic fieldValid,
  input logic tValid,
  input logic sValid,
  input logic sfLock,
  input logic cvErr,
  input logic symErr
);
  p_field_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |=> !fieldValid);

  p_cv_after_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    cvErr |-> $past(sampleValid) && $past(linePos ^ lineNeg));

  p_sym_after_both_r5: assert property (@(posedge clk) disable iff (!rstN)
    symErr |-> $past(sampleValid && linePos && lineNeg));

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sfLock) |-> fieldValid);

  p_strobe_needs_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tValid || sValid) |-> (fieldValid && sfLock));

  p_strobe_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(tValid && sValid));

  p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sfLock) |-> fieldValid);
endmodule

bind amiSuperframeRx amiSuperframeRxChecker chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .linePos(linePos),
  .lineNeg(lineNeg), .fieldValid(fieldValid), .tValid(tValid), .sValid(sValid),
  .sfLock(sfLock), .cvErr(cvErr), .symErr(symErr)
);

// File: tb/amiSuperframeRx_test.sv
`timescale 1ns/1ps
module amiSuperframeRx_test;
  localparam int HALF = 4;
  localparam int WATCHDOG_CYCLES = 200000;
  localparam int NVEC = 20;
  // {mKind[1:0] (0 space,1 mark,2 marker), dc, lock, tValid, tBit, sValid, sBit}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b10_1_0_0000, 8'b01_0_0_0000, 8'b00_0_0_0000, 8'b01_0_0_0000,
    8'b10_1_1_0000, 8'b01_0_1_1100, 8'b00_0_1_0010, 8'b00_0_1_1000,
    8'b10_0_1_0000, 8'b00_0_1_1000, 8'b01_0_1_0011, 8'b01_0_1_1100,
    8'b00_0_1_0000, 8'b01_0_1_1100, 8'b10_1_0_0000, 8'b00_0_0_0000,
    8'b00_0_0_0000, 8'b01_0_0_0000, 8'b10_1_1_0000, 8'b01_0_1_1100
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleValid = 1'b0, burstStart = 1'b0, linePos = 1'b0, lineNeg = 1'b0;
  logic fieldValid, tValid, tBit, sValid, sBit, sfLock, cvErr, symErr;
  logic [7:0] b1Out, b2Out;
  logic [3:0] dOut;

  int total = 0, bad = 0, cvSeen = 0, symSeen = 0;
  bit done = 0;
  logic benchPos = 1'b0;
  logic gField, gFieldAfter, gLock, gT, gTB, gS, gSB;
  logic [7:0] gB1, gB2;
  logic [3:0] gD;

  amiSuperframeRx uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .burstStart(burstStart),
    .linePos(linePos), .lineNeg(lineNeg), .fieldValid(fieldValid), .b1Out(b1Out),
    .b2Out(b2Out), .dOut(dOut), .tValid(tValid), .tBit(tBit), .sValid(sValid),
    .sBit(sBit), .sfLock(sfLock), .cvErr(cvErr), .symErr(symErr)
  );

  always #HALF clk = ~clk;

  always @(negedge clk) begin
    if (cvErr) cvSeen++;
    if (symErr) symSeen++;
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic driveMark(input logic one, input bit viol, input logic start);
    @(negedge clk);
    sampleValid = 1'b1;
    burstStart = start;
    if (one) begin
      if (!viol) benchPos = ~benchPos;
      linePos = benchPos;
      lineNeg = ~benchPos;
    end else begin
      linePos = 1'b0;
      lineNeg = 1'b0;
    end
  endtask

  task automatic driveOther(input logic valid);
    @(negedge clk);
    sampleValid = valid;
    burstStart = 1'b0;
    linePos = 1'b1;
    lineNeg = 1'b1;
  endtask

  task automatic goIdle();
    sampleValid = 1'b0;
    burstStart = 1'b0;
    linePos = 1'b0;
    lineNeg = 1'b0;
  endtask

  task automatic sendBurst(input logic [7:0] b1, input logic [7:0] b2, input logic [3:0] d,
                           input int mKind, input bit dc, input bit gaps,
                           input int errPos, input int errKind);
    logic [19:0] bits;
    bits = {b1, b2, d};
    driveMark(1'b1, 1'b0, 1'b1);
    for (int k = 1; k <= 20; k++) begin
      if (gaps) driveOther(1'b0);
      if (errKind == 2 && k == errPos) driveOther(1'b1);
      else if ((errKind == 1 && k == errPos) ||
               (errKind == 3 && (k == errPos || k == errPos + 1)))
        driveMark(1'b1, 1'b1, 1'b0);
      else driveMark(bits[20-k], 1'b0, 1'b0);
    end
    if (gaps) driveOther(1'b0);
    driveMark(mKind != 0, mKind == 2, 1'b0);
    @(negedge clk);
    gField = fieldValid; gB1 = b1Out; gB2 = b2Out; gD = dOut;
    gLock = sfLock; gT = tValid; gTB = tBit; gS = sValid; gSB = sBit;
    if (dc) begin
      sampleValid = 1'b1;
      burstStart = 1'b0;
      linePos = benchPos;
      lineNeg = ~benchPos;
    end else goIdle();
    @(negedge clk);
    gFieldAfter = fieldValid;
    goIdle();
    @(negedge clk);
  endtask

  task automatic doReset();
    goIdle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * WATCHDOG_CYCLES);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cv0, sym0;
    logic [7:0] eb1, eb2;
    logic [3:0] ed;
    @(negedge clk);
    chk("R1 fieldValid in reset", fieldValid, 0);
    doReset();
    chk("R1 sfLock", sfLock, 0);
    chk("R1 b1Out", b1Out, 0);
    chk("R1 b2Out", b2Out, 0);
    chk("R1 dOut", dOut, 0);
    chk("R1 strobes", {tValid, sValid, cvErr, symErr}, 0);

    // superframe table: marker detection, lock, T/S extraction, loss and realign
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] v;
      v = VEC[i];
      eb1 = 8'(i * 37 + 5);
      eb2 = 8'(i * 91 + 3);
      ed  = 4'(i * 5 + 2);
      cv0 = cvSeen;
      sym0 = symSeen;
      sendBurst(eb1, eb2, ed, int'(v[7:6]), v[5], 1'b0, 0, 0);
      chk($sformatf("R3 fieldValid burst %0d", i), gField, 1);
      chk($sformatf("R3 fieldValid drops burst %0d", i), gFieldAfter, 0);
      chk($sformatf("R2 b1Out burst %0d", i), gB1, eb1);
      chk($sformatf("R2 b2Out burst %0d", i), gB2, eb2);
      chk($sformatf("R2 dOut burst %0d", i), gD, ed);
      chk($sformatf("R7 R9 sfLock burst %0d", i), gLock, v[4]);
      chk($sformatf("R8 tValid burst %0d", i), gT, v[3]);
      if (v[3]) chk($sformatf("R8 tBit burst %0d", i), gTB, v[2]);
      chk($sformatf("R8 sValid burst %0d", i), gS, v[1]);
      if (v[1]) chk($sformatf("R8 sBit burst %0d", i), gSB, v[0]);
      chk($sformatf("R6 no cvErr (marker and trailing bit) burst %0d", i), cvSeen - cv0, 0);
      chk($sformatf("R6 no symErr burst %0d", i), symSeen - sym0, 0);
    end

    // single violation in B1 at bit position 3
    doReset();
    cv0 = cvSeen;
    sendBurst(8'h00, 8'h00, 4'h0, 0, 1'b0, 1'b0, 3, 1);
    chk("R4 one cvErr for one violation", cvSeen - cv0, 1);
    chk("R4 violating mark decodes as 1", gB1, 8'b0010_0000);

    // two back-to-back violations at the start of B2: reference kept after the first
    cv0 = cvSeen;
    sendBurst(8'h00, 8'h00, 4'h0, 0, 1'b0, 1'b0, 10, 3);
    chk("R4 second violation still caught", cvSeen - cv0, 2);
    chk("R4 b2Out with violations", gB2, 8'b0110_0000);

    // invalid symbol on the second D bit
    cv0 = cvSeen;
    sym0 = symSeen;
    sendBurst(8'h81, 8'h42, 4'hF, 0, 1'b0, 1'b0, 18, 2);
    chk("R5 symErr raised", symSeen - sym0, 1);
    chk("R5 invalid decodes 0", gD, 4'b1011);
    chk("R5 polarity unchanged, no cvErr", cvSeen - cv0, 0);

    // unqualified samples between every bit
    cv0 = cvSeen;
    sym0 = symSeen;
    sendBurst(8'hA5, 8'h3C, 4'h9, 1, 1'b0, 1'b1, 0, 0);
    chk("R6 b1Out with gaps", gB1, 8'hA5);
    chk("R6 b2Out with gaps", gB2, 8'h3C);
    chk("R6 dOut with gaps", gD, 4'h9);
    chk("R6 gaps raise no symErr", symSeen - sym0, 0);
    chk("R6 gaps raise no cvErr", cvSeen - cv0, 0);
    chk("R8 no strobe unlocked", {gT, gS}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule